// File: doc/BRIEF.md
# Hierarchical Interrupt Aggregation Controller

This block collects interrupt events from three kinds of source and drives one registered interrupt request pin. The first kind is host MAC events, which arrive as single-cycle pulses. The second is power management sources: a wake detector and energy detectors on two ports. The third is an internal 16-bit down-counting timer. Each event latches into a sticky status bit. A status bit reaches the pin only when its own enable bit is set and the global output enable is also set.

Power management sources are nested one level deeper than the other sources. Each one has a local sticky status bit and a local enable bit in a power management control register. The enabled local bits are ORed into a single read-only summary bit in the top-level status register, and that summary bit has its own top-level enable.

The timer behaves as follows:
- It reloads from a programmed value when its run bit goes from 0 to 1.
- It then decrements once per prescaler tick.
- It raises its status bit when the count wraps from zero to FFFFh.

A host reaches all registers over a plain 32-bit bus. Registers are addressed by word, and reads are combinational.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is low. The register map by word address is: 0 top status, 1 top enable, 2 IRQ configuration, 3 power management control, 4 timer configuration.
- R2: A pulse on `macEvent[i]` sets top status bit i, which stays set. Writing 1 to that bit at address 0 clears it. Writing 0 to it leaves it unchanged.
- R3: `irqOut` is a register. It goes high one clock after IRQ_EN is set and some bit is set in both top status and top enable. It goes low one clock after that condition goes away.
- R4: `irqOut` stays low while bit 8 (IRQ_EN) of address 2 is 0, whatever the status and enable bits hold.
- R5: In address 3, a pulse on `pmEvent` sets a local sticky status bit. The wake source sets bit 0, port 1 energy detect sets bit 1, and port 2 energy detect sets bit 2. These bits set whatever the enables hold, and writing 1 to a bit clears it. The local enables sit at bit 9 (wake), bit 14 (port 1) and bit 15 (port 2).
- R6: Top status bit 17 reads as the OR of the local status bits ANDed with their local enables. Writes to it have no effect. Its top enable is bit 17 of address 1.
- R7: In address 4, bit 29 is the run bit and bits 15:0 hold the reload value. When the run bit rises, the count loads the reload value. The count then decrements each tick. The tick after the count reaches zero wraps it to FFFFh and sets top status bit 19. Bit 19 is cleared by writing 1 to it and is enabled by bit 19 of address 1.
- R8: While the run bit is 0 the count holds its value and top status bit 19 is never set.
- R9: When an event and a write-1 clear reach the same status bit in the same cycle, the bit stays set.
- R10: Only the MAC bits, bit 17 and bit 19 of the top enable are writable, and every other bit reads 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Word address of the register |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| macEvent | input | MAC_N | Host MAC event pulses |
| pmEvent | input | 3 | Power management pulses: wake, port 1 energy, port 2 energy |
| irqOut | output | 1 | Registered interrupt request, active high |

## Verification
The assertions assume that event inputs are clean pulses sampled on the clock edge. They also assume that a single write strobe touches at most one register per cycle. The stimulus keeps to this by changing events and bus signals only on the falling edge and by holding each for exactly one rising edge. The write-1 clears that are meant to collide with an event are issued deliberately in the same cycle as that event. The checks on the timer assume a prescaler tick on every clock, which is the default parameter value.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int DATA_W        = 32;
  localparam int PM_SRC_N      = 3;
  localparam int PM_SUM_BIT    = 17;
  localparam int TIMER_ST_BIT  = 19;
  localparam int IRQ_EN_BIT    = 8;
  localparam int TIMER_RUN_BIT = 29;

  // Read source selected by the address decoder.
  typedef enum logic [2:0] {
    RD_STATUS   = 3'd0,
    RD_ENABLE   = 3'd1,
    RD_IRQCFG   = 3'd2,
    RD_PMCTRL   = 3'd3,
    RD_TIMERCFG = 3'd4,
    RD_NONE     = 3'd5
  } rdSel_e;

  // Write strobes from control to datapath.
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrIrqCfg;
    logic wrPmCtrl;
    logic wrTimerCfg;
  } regStrobe_t;

  // Position of the local enable for each power management source.
  function automatic int pmEnPos(input int idx);
    case (idx)
      0:       return 9;
      1:       return 14;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe,
  output rdSel_e            rdSel
);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_IRQCFG   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PMCTRL   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TIMERCFG = ADDR_W'(4);

  always_comb begin
    strobe = '0;
    rdSel  = RD_NONE;
    case (regAddr)
      A_STATUS: begin
        rdSel           = RD_STATUS;
        strobe.wrStatus = regWrEn;
      end
      A_ENABLE: begin
        rdSel           = RD_ENABLE;
        strobe.wrEnable = regWrEn;
      end
      A_IRQCFG: begin
        rdSel           = RD_IRQCFG;
        strobe.wrIrqCfg = regWrEn;
      end
      A_PMCTRL: begin
        rdSel           = RD_PMCTRL;
        strobe.wrPmCtrl = regWrEn;
      end
      A_TIMERCFG: begin
        rdSel             = RD_TIMERCFG;
        strobe.wrTimerCfg = regWrEn;
      end
      default: begin
        rdSel  = RD_NONE;
        strobe = '0;
      end
    endcase
  end
endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int MAC_N    = 8,
  parameter int TIMER_W  = 16,
  parameter int TICK_DIV = 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  rdSel_e              rdSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [MAC_N-1:0]    macEvent,
  input  logic [PM_SRC_N-1:0] pmEvent,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);
  localparam logic [DATA_W-1:0] MAC_MASK = DATA_W'((64'd1 << MAC_N) - 64'd1);
  localparam logic [DATA_W-1:0] EN_MASK  = MAC_MASK
                                         | (DATA_W'(1) << PM_SUM_BIT)
                                         | (DATA_W'(1) << TIMER_ST_BIT);

  // ---------------- state ----------------
  logic [MAC_N-1:0]    macSt;
  logic                timerSt;
  logic [DATA_W-1:0]   enReg;
  logic                irqEn;
  logic [PM_SRC_N-1:0] pmSt;
  logic [PM_SRC_N-1:0] pmEn;
  logic                timerRun;
  logic [TIMER_W-1:0]  reload;
  logic [TIMER_W-1:0]  count;

  logic                tick;
  logic                runRise;
  logic                wrapEvt;
  logic                pmSummary;
  logic [DATA_W-1:0]   statusVec;
  logic [DATA_W-1:0]   pmCtrlVec;
  logic [DATA_W-1:0]   timerCfgVec;

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  // ---------------- MAC sticky status ----------------
  logic [MAC_N-1:0] clrMac;
  assign clrMac = strobe.wrStatus ? wrData[MAC_N-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) macSt <= '0;
    else       macSt <= (macSt & ~clrMac) | macEvent;
  end

  // ---------------- power management level ----------------
  logic [PM_SRC_N-1:0] clrPm;
  assign clrPm = strobe.wrPmCtrl ? wrData[PM_SRC_N-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pmSt <= '0;
    else       pmSt <= (pmSt & ~clrPm) | pmEvent;
  end

  for (genvar i = 0; i < PM_SRC_N; i++) begin : g_pmEn
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                pmEn[i] <= 1'b0;
      else if (strobe.wrPmCtrl) pmEn[i] <= wrData[pmEnPos(i)];
    end
  end

  assign pmSummary = |(pmSt & pmEn);

  always_comb begin
    pmCtrlVec = '0;
    pmCtrlVec[PM_SRC_N-1:0] = pmSt;
    for (int i = 0; i < PM_SRC_N; i++) pmCtrlVec[pmEnPos(i)] = pmEn[i];
  end

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      irqEn    <= 1'b0;
      timerRun <= 1'b0;
      reload   <= '0;
    end else begin
      if (strobe.wrEnable)   enReg <= wrData & EN_MASK;
      if (strobe.wrIrqCfg)   irqEn <= wrData[IRQ_EN_BIT];
      if (strobe.wrTimerCfg) begin
        timerRun <= wrData[TIMER_RUN_BIT];
        reload   <= wrData[TIMER_W-1:0];
      end
    end
  end

  // ---------------- timer ----------------
  assign runRise = strobe.wrTimerCfg && wrData[TIMER_RUN_BIT] && !timerRun;

  if (TICK_DIV <= 1) begin : g_tickEvery
    assign tick = 1'b1;
  end else begin : g_tickDiv
    localparam int PW = $clog2(TICK_DIV);
    logic [PW-1:0] presc;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                      presc <= '0;
      else if (runRise || !timerRun)  presc <= '0;
      else if (presc == PW'(TICK_DIV - 1)) presc <= '0;
      else                            presc <= presc + PW'(1);
    end
    assign tick = (presc == PW'(TICK_DIV - 1));
  end

  assign wrapEvt = timerRun && tick && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 count <= '0;
    else if (runRise)          count <= wrData[TIMER_W-1:0];
    else if (timerRun && tick) count <= count - TIMER_W'(1);
  end

  logic clrTimer;
  assign clrTimer = strobe.wrStatus && wrData[TIMER_ST_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) timerSt <= 1'b0;
    else       timerSt <= (timerSt & ~clrTimer) | wrapEvt;
  end

  always_comb begin
    timerCfgVec = '0;
    timerCfgVec[TIMER_RUN_BIT] = timerRun;
    timerCfgVec[TIMER_W-1:0]   = reload;
  end

  // ---------------- top level status and pin ----------------
  always_comb begin
    statusVec = '0;
    statusVec[MAC_N-1:0]   = macSt;
    statusVec[PM_SUM_BIT]  = pmSummary;
    statusVec[TIMER_ST_BIT] = timerSt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= irqEn && |(statusVec & enReg);
  end

  always_comb begin
    case (rdSel)
      RD_STATUS:   rdData = statusVec;
      RD_ENABLE:   rdData = enReg;
      RD_IRQCFG:   rdData = DATA_W'(irqEn) << IRQ_EN_BIT;
      RD_PMCTRL:   rdData = pmCtrlVec;
      RD_TIMERCFG: rdData = timerCfgVec;
      default:     rdData = '0;
    endcase
  end

  // ---------------- assertions ----------------
  a_r4_pin_gated: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |=> !irqOut);

  a_r6_pm_reaches_pin: assert property (@(posedge clk) disable iff (!rstN)
    (irqEn && enReg[PM_SUM_BIT] && |(pmSt & pmEn)) |=> irqOut);

  a_r7_wrap_sets_status: assert property (@(posedge clk) disable iff (!rstN)
    (timerRun && tick && count == '0) |=> (timerSt && count == '1));

  a_r8_count_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!timerRun && !strobe.wrTimerCfg) |=> ($stable(count) && !$rose(timerSt)));

  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rstN)
    (|macEvent) |=> ((macSt & $past(macEvent)) == $past(macEvent)));

  a_r5_pm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (|pmEvent) |=> ((pmSt & $past(pmEvent)) == $past(pmEvent)));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int MAC_N    = 8,
  parameter int TIMER_W  = 16,
  parameter int TICK_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [MAC_N-1:0]  macEvent,
  input  logic [2:0]        pmEvent,
  output logic              irqOut
);
  regStrobe_t strobe;
  rdSel_e     rdSel;

  irq_agg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  irq_agg_dp #(
    .MAC_N    (MAC_N),
    .TIMER_W  (TIMER_W),
    .TICK_DIV (TICK_DIV)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdSel    (rdSel),
    .wrData   (regWrData),
    .macEvent (macEvent),
    .pmEvent  (pmEvent),
    .rdData   (regRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int MAC_N  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [31:0]       regRdData;
  logic [MAC_N-1:0]  macEvent = '0;
  logic [2:0]        pmEvent = '0;
  logic              irqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  irq_aggregator #(.ADDR_W(ADDR_W), .MAC_N(MAC_N)) i_irq_aggregator (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .macEvent(macEvent),
    .pmEvent(pmEvent), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Scoreboard queues: kind 0 = register read, kind 1 = pin.
  int          kindQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];
  event        sampleEv;

  initial begin
    forever begin
      @(sampleEv);
      while (kindQ.size() > 0) begin
        int          k;
        logic [31:0] e;
        logic [31:0] act;
        string       t;
        k = kindQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        act = (k == 0) ? regRdData : {31'b0, irqOut};
        checks++;
        if (act !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  task automatic wrReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic wrRegMac(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                          input logic [MAC_N-1:0] m);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1; macEvent = m;
    @(posedge clk); #1;
    regWrEn = 1'b0; macEvent = '0;
  endtask

  task automatic pulseMac(input logic [MAC_N-1:0] m);
    @(negedge clk); macEvent = m;
    @(posedge clk); #1; macEvent = '0;
  endtask

  task automatic pulsePm(input logic [2:0] p);
    @(negedge clk); pmEvent = p;
    @(posedge clk); #1; pmEvent = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expReg(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    regAddr = a;
    #1;
    kindQ.push_back(0); expQ.push_back(e); tagQ.push_back(t);
    ->sampleEv;
    #1;
  endtask

  task automatic expIrq(input logic e, input string t);
    @(negedge clk);
    #1;
    kindQ.push_back(1); expQ.push_back({31'b0, e}); tagQ.push_back(t);
    ->sampleEv;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expReg(0, 32'h0, "R1 status");
    expReg(1, 32'h0, "R1 enable");
    expReg(2, 32'h0, "R1 irqcfg");
    expReg(3, 32'h0, "R1 pmctrl");
    expReg(4, 32'h0, "R1 timercfg");
    expIrq(1'b0, "R1 pin");
    expReg(7, 32'h0, "R10 unmapped");

    // R2/R3/R4 MAC path
    pulseMac(8'h08);
    expReg(0, 32'h8, "R2 sticky set");
    expIrq(1'b0, "R3 no enable");
    wrReg(1, 32'h8);
    expIrq(1'b0, "R4 gated");
    expIrq(1'b0, "R4 gated settled");
    wrReg(2, 32'h100);
    expIrq(1'b0, "R3 one cycle lag");
    expIrq(1'b1, "R3 asserted");
    expReg(2, 32'h100, "R4 irqcfg readback");
    wrReg(0, 32'h0);
    expReg(0, 32'h8, "R2 write zero no effect");
    wrReg(0, 32'h8);
    expIrq(1'b1, "R3 deassert lag");
    expIrq(1'b0, "R3 deasserted");
    expReg(0, 32'h0, "R2 cleared");

    // R10 enable mask
    wrReg(1, 32'hFFFF_FFFF);
    expReg(1, 32'h000A_00FF, "R10 enable mask");
    wrReg(1, 32'h0);

    // R5/R6 power management
    pulsePm(3'b010);
    expReg(3, 32'h2, "R5 port1 sticky");
    expReg(0, 32'h0, "R6 summary needs local enable");
    wrReg(3, 32'h4000);
    expReg(3, 32'h4002, "R5 enable bit14");
    expReg(0, 32'h2_0000, "R6 summary set");
    wrReg(1, 32'h2_0000);
    idle(1);
    expIrq(1'b1, "R6 summary drives pin");
    wrReg(0, 32'h2_0000);
    expReg(0, 32'h2_0000, "R6 summary read-only");
    pulsePm(3'b100);
    expReg(3, 32'h4006, "R5 port2 sticky");
    wrReg(3, 32'h4006);
    expReg(3, 32'h4000, "R5 w1c");
    expReg(0, 32'h0, "R6 summary cleared");
    idle(1);
    expIrq(1'b0, "R6 pin released");
    wrReg(3, 32'h0200);
    pulsePm(3'b001);
    expReg(0, 32'h2_0000, "R5 wake enable bit9");
    wrReg(3, 32'h0201);
    expReg(3, 32'h0200, "R5 wake cleared");
    wrReg(3, 32'h0);

    // R4 global gate with all enables
    wrReg(1, 32'hFFFF_FFFF);
    wrReg(2, 32'h0);
    pulseMac(8'h01);
    idle(2);
    expIrq(1'b0, "R4 all enabled but gated");
    expReg(0, 32'h1, "R2 bit0 set");
    wrReg(2, 32'h100);
    idle(1);
    expIrq(1'b1, "R4 ungated");
    wrReg(0, 32'h1);
    wrReg(1, 32'h8_0000);

    // R7 timer wrap, reload 3
    wrReg(4, 32'h2000_0003);
    expReg(4, 32'h2000_0003, "R7 cfg readback");
    expReg(0, 32'h0, "R7 before wrap a");
    expReg(0, 32'h0, "R7 before wrap b");
    expReg(0, 32'h0, "R7 at zero");
    expReg(0, 32'h8_0000, "R7 wrap sets");
    expIrq(1'b1, "R7 pin");
    wrReg(4, 32'h0);
    wrReg(0, 32'h0);
    expReg(0, 32'h8_0000, "R7 write zero no effect");
    wrReg(0, 32'h8_0000);
    expReg(0, 32'h0, "R7 w1c");

    // R8 stopped timer
    wrReg(4, 32'h1);
    idle(6);
    expReg(0, 32'h0, "R8 no run no wrap");
    expReg(4, 32'h1, "R8 cfg readback");
    wrReg(4, 32'h2000_0005);
    idle(2);
    wrReg(4, 32'h5);
    idle(10);
    expReg(0, 32'h0, "R8 stopped mid count");

    // R7 reload 0 boundary
    wrReg(4, 32'h2000_0000);
    expReg(0, 32'h0, "R7 reload0 before");
    expReg(0, 32'h8_0000, "R7 reload0 wrap");
    wrReg(4, 32'h0);
    wrReg(0, 32'h8_0000);

    // R7 restart reloads
    wrReg(4, 32'h2000_0002);
    idle(2);
    expReg(0, 32'h0, "R7 restart at zero");
    expReg(0, 32'h8_0000, "R7 restart wrap");
    wrReg(4, 32'h0);
    wrReg(0, 32'h8_0000);

    // R9 event wins over clear
    wrReg(1, 32'h0);
    pulseMac(8'h08);
    wrRegMac(0, 32'h8, 8'h08);
    expReg(0, 32'h8, "R9 event wins");
    wrRegMac(0, 32'h8, 8'h10);
    expReg(0, 32'h10, "R9 other bit clears");
    wrReg(0, 32'hFF);
    expReg(0, 32'h0, "R2 all cleared");

    idle(2);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule